// File: doc/BRIEF.md
# Circular Buffer Pointer and Status Flag Manager

This block tracks three addresses into a circular audio store: a write pointer that advances as encoded data is written, a read pointer that advances as data is played out, and a committed (valid) write pointer marking the end of data known to be good. On each falling edge of a block-rate clock the write pointer is captured into a snapshot; a later host validate command moves that snapshot into the committed pointer. The gap between the committed pointer and the read pointer is reported as a residual word.

Around the pointers the block keeps the status a host polls: a live empty flag, a full flag, a read-once overflow flag, encode-halt and decode-halt indications, an error flag fed by a frame-error input sampled in one of four ways, and an encode-running state. A status-read strobe clears the read-to-clear flags. The address-clear commands re-initialise the pointers and the flags tied to them.

Top module: `buf_ptr_status`

## Requirements
- R1: After a synchronous reset every flag and `enc_run` are 0, `buf_empty` is 1 and `residual` is 0.
- R2: A 1-to-0 transition of `blk_clk` between two clock edges captures the write pointer value held before that cycle's write advance; a rising edge or a steady level captures nothing. `validate` loads the committed pointer with the snapshot held before that cycle, so a capture and a validate in the same cycle commit the older snapshot.
- R3: `buf_empty` is 1 exactly when the committed pointer equals the read pointer.
- R4: `residual` is (committed minus read) modulo 2^ADDR_W, left-aligned so that its top ADDR_W bits land in `residual[RES_W-1:1]` (truncated when wider, zero-padded below when narrower); bit 0 is always 0. The value is correct across the wrap point.
- R5: `buf_full` sets when a write advance with no read advance and no address clear brings the write pointer onto the read pointer. It clears on any read advance or address clear; an address clear that makes the two pointers equal never sets it.
- R6: `ovf_once` sets on the same event as `buf_full`. A status read clears it even while `buf_full` stays 1; a new set event in the same cycle as a status read wins. Address clears and reset clear it.
- R7: `dec_halt` sets when the committed and read pointers become equal through a read advance or a validate. A status read clears it (a set in the same cycle wins); an address clear clears it and takes priority.
- R8: With the memory system on, `jit_err` sets according to `err_mode`: 00 sets on a falling edge of `frm_clk` while `frm_err` is 0; 01 on a rising edge of `frm_clk` while `frm_err` is 0; 10 while `frm_err` is 0; 11 while `frm_err` is 1.
- R9: `jit_err` is cleared by a status read (a set in the same cycle wins) and is held at 0 whenever `mem_on` is 0.
- R10: `enc_halt` sets whenever the error flag or the overflow flag is set by its event; a status read leaves it alone, and only an address clear (which wins) or reset clears it.
- R11: `enc_run` sets on `enc_start`. It clears on `enc_stop`, when `mem_on` is 0, when the error or full flag is set or being set; any clearing condition beats a start in the same cycle.
- R12: `wr_clr` sets the write pointer, the snapshot and the committed pointer to 0; `rd_clr` sets the read pointer to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_on | input | 1 | Memory system enabled |
| wr_adv | input | 1 | Write pointer advance strobe |
| rd_adv | input | 1 | Read pointer advance strobe |
| wr_clr | input | 1 | Write address clear command |
| rd_clr | input | 1 | Read address clear command |
| blk_clk | input | 1 | Block-rate clock, sampled on clk |
| validate | input | 1 | Commit latched snapshot to committed pointer |
| stat_rd | input | 1 | Status-read strobe |
| frm_clk | input | 1 | Frame clock for error sampling |
| frm_err | input | 1 | Frame-error input |
| err_mode | input | 2 | Error sampling method |
| enc_start | input | 1 | Encode start command |
| enc_stop | input | 1 | Encode stop command |
| buf_empty | output | 1 | Committed pointer equals read pointer |
| buf_full | output | 1 | Write pointer has caught the read pointer |
| ovf_once | output | 1 | Read-once overflow indication |
| enc_halt | output | 1 | Encoding halted by internal cause |
| dec_halt | output | 1 | Valid data ran out |
| jit_err | output | 1 | Frame error flag |
| enc_run | output | 1 | Encode running state |
| residual | output | RES_W | Left-aligned valid-data count, LSB 0 |

## Verification
The residual and empty outputs are swept over every pairing of read and committed positions in a 16-entry configuration, so a wrong subtraction, missing wrap or misplaced alignment shows up in at least one pair. The full flag is driven to trip from every read position, which separates an off-by-one compare from the correct overtaking test. Each error mode is shown both a matching and a non-matching frame-clock edge or level, telling the four encodings apart, and same-cycle collisions (capture with validate, set with status read, start with stop) pin down the stated priorities.

// File: rtl/bps_pkg.sv
package bps_pkg;

    typedef enum logic [1:0] {
        ERR_FALL_LOW = 2'b00,
        ERR_RISE_LOW = 2'b01,
        ERR_LVL_LOW  = 2'b10,
        ERR_LVL_HIGH = 2'b11
    } err_mode_e;

    // Events produced by the pointer unit for the flag unit.
    typedef struct packed {
        logic full_set;
        logic drained;
        logic addr_clr;
        logic rd_step;
    } ptr_evt_t;

    typedef struct packed {
        logic full;
        logic ovf;
        logic enc_halt;
        logic dec_halt;
        logic err;
        logic enc_run;
    } flag_vec_t;

    function automatic logic err_match(err_mode_e mode, logic fall, logic rise, logic lvl);
        logic hit;
        case (mode)
            ERR_FALL_LOW: hit = fall & ~lvl;
            ERR_RISE_LOW: hit = rise & ~lvl;
            ERR_LVL_LOW:  hit = ~lvl;
            default:      hit = lvl;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/bps_edge_det.sv
module bps_edge_det (
    input  logic clk,
    input  logic sig,
    output logic rise,
    output logic fall
);
    // History follows the input even in reset so no false edge appears after it.
    logic sig_q;

    always_ff @(posedge clk) begin
        sig_q <= sig;
    end

    assign rise = sig & ~sig_q;
    assign fall = ~sig & sig_q;
endmodule

// File: rtl/bps_err_sampler.sv
module bps_err_sampler
    import bps_pkg::*;
(
    input  logic      clk,
    input  logic      frm_clk,
    input  logic      frm_err,
    input  err_mode_e mode,
    output logic      hit
);
    logic fc_rise;
    logic fc_fall;

    bps_edge_det u_fc_edge (
        .clk  (clk),
        .sig  (frm_clk),
        .rise (fc_rise),
        .fall (fc_fall)
    );

    assign hit = err_match(mode, fc_fall, fc_rise, frm_err);
endmodule

// File: rtl/bps_ptr_unit.sv
module bps_ptr_unit
    import bps_pkg::*;
#(
    parameter int ADDR_W = 21
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_adv,
    input  logic              rd_adv,
    input  logic              wr_clr,
    input  logic              rd_clr,
    input  logic              blk_fall,
    input  logic              validate,
    output logic [ADDR_W-1:0] vwa,
    output logic [ADDR_W-1:0] ra,
    output logic              empty,
    output ptr_evt_t          evt
);
    localparam logic [ADDR_W-1:0] ONE  = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] ZERO = '0;

    logic [ADDR_W-1:0] wa, snap;
    logic [ADDR_W-1:0] wa_n, ra_n, snap_n, vwa_n;
    logic              any_clr;

    always_comb begin
        any_clr = wr_clr | rd_clr;
        wa_n    = wr_clr ? ZERO : (wr_adv ? wa + ONE : wa);
        ra_n    = rd_clr ? ZERO : (rd_adv ? ra + ONE : ra);
        snap_n  = wr_clr ? ZERO : (blk_fall ? wa : snap);
        vwa_n   = wr_clr ? ZERO : (validate ? snap : vwa);
        empty   = (vwa == ra);

        evt.addr_clr = any_clr;
        evt.rd_step  = rd_adv;
        evt.full_set = wr_adv & ~rd_adv & ~any_clr & ((wa + ONE) == ra);
        evt.drained  = ~any_clr & ~empty & (vwa_n == ra_n);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wa   <= ZERO;
            ra   <= ZERO;
            snap <= ZERO;
            vwa  <= ZERO;
        end else begin
            wa   <= wa_n;
            ra   <= ra_n;
            snap <= snap_n;
            vwa  <= vwa_n;
        end
    end
endmodule

// File: rtl/bps_flag_unit.sv
module bps_flag_unit
    import bps_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      mem_on,
    input  logic      stat_rd,
    input  logic      enc_start,
    input  logic      enc_stop,
    input  logic      err_hit,
    input  ptr_evt_t  evt,
    output flag_vec_t flags
);
    flag_vec_t cur, nxt;
    logic      err_set;
    logic      kill;

    always_comb begin
        err_set = err_hit & mem_on;
        nxt     = cur;

        // full: cleared by any read step or address clear
        if (evt.addr_clr | evt.rd_step) nxt.full = 1'b0;
        else if (evt.full_set)          nxt.full = 1'b1;

        // read-once overflow: new event beats status read
        if (evt.addr_clr)      nxt.ovf = 1'b0;
        else if (evt.full_set) nxt.ovf = 1'b1;
        else if (stat_rd)      nxt.ovf = 1'b0;

        if (evt.addr_clr)     nxt.dec_halt = 1'b0;
        else if (evt.drained) nxt.dec_halt = 1'b1;
        else if (stat_rd)     nxt.dec_halt = 1'b0;

        if (!mem_on)      nxt.err = 1'b0;
        else if (err_set) nxt.err = 1'b1;
        else if (stat_rd) nxt.err = 1'b0;

        if (evt.addr_clr)                nxt.enc_halt = 1'b0;
        else if (err_set | evt.full_set) nxt.enc_halt = 1'b1;

        // encode state: every stop condition outranks a start
        kill = enc_stop | ~mem_on | err_set | cur.err | evt.full_set | cur.full;
        if (kill)           nxt.enc_run = 1'b0;
        else if (enc_start) nxt.enc_run = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) cur <= '0;
        else     cur <= nxt;
    end

    assign flags = cur;
endmodule

// File: rtl/buf_ptr_status.sv
module buf_ptr_status
    import bps_pkg::*;
#(
    parameter int ADDR_W = 21,
    parameter int RES_W  = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mem_on,
    input  logic             wr_adv,
    input  logic             rd_adv,
    input  logic             wr_clr,
    input  logic             rd_clr,
    input  logic             blk_clk,
    input  logic             validate,
    input  logic             stat_rd,
    input  logic             frm_clk,
    input  logic             frm_err,
    input  logic [1:0]       err_mode,
    input  logic             enc_start,
    input  logic             enc_stop,
    output logic             buf_empty,
    output logic             buf_full,
    output logic             ovf_once,
    output logic             enc_halt,
    output logic             dec_halt,
    output logic             jit_err,
    output logic             enc_run,
    output logic [RES_W-1:0] residual
);
    localparam int HI_W = RES_W - 1;

    logic [ADDR_W-1:0] vwa, ra, diff;
    logic [HI_W-1:0]   res_hi;
    logic              blk_rise, blk_fall;
    logic              err_hit;
    ptr_evt_t          evt;
    flag_vec_t         flags;

    bps_edge_det u_blk_edge (
        .clk  (clk),
        .sig  (blk_clk),
        .rise (blk_rise),
        .fall (blk_fall)
    );

    bps_ptr_unit #(.ADDR_W(ADDR_W)) u_ptr (
        .clk      (clk),
        .rst      (rst),
        .wr_adv   (wr_adv),
        .rd_adv   (rd_adv),
        .wr_clr   (wr_clr),
        .rd_clr   (rd_clr),
        .blk_fall (blk_fall),
        .validate (validate),
        .vwa      (vwa),
        .ra       (ra),
        .empty    (buf_empty),
        .evt      (evt)
    );

    bps_err_sampler u_err (
        .clk     (clk),
        .frm_clk (frm_clk),
        .frm_err (frm_err),
        .mode    (err_mode_e'(err_mode)),
        .hit     (err_hit)
    );

    bps_flag_unit u_flags (
        .clk       (clk),
        .rst       (rst),
        .mem_on    (mem_on),
        .stat_rd   (stat_rd),
        .enc_start (enc_start),
        .enc_stop  (enc_stop),
        .err_hit   (err_hit),
        .evt       (evt),
        .flags     (flags)
    );

    // Modular subtraction keeps the count right across the wrap point.
    assign diff = vwa - ra;

    generate
        if (ADDR_W >= HI_W) begin : g_res_trunc
            assign res_hi = diff[ADDR_W-1 -: HI_W];
        end else begin : g_res_pad
            assign res_hi = {diff, {(HI_W-ADDR_W){1'b0}}};
        end
    endgenerate

    assign residual = {res_hi, 1'b0};
    assign buf_full = flags.full;
    assign ovf_once = flags.ovf;
    assign enc_halt = flags.enc_halt;
    assign dec_halt = flags.dec_halt;
    assign jit_err  = flags.err;
    assign enc_run  = flags.enc_run;

    logic unused_ok;
    assign unused_ok = blk_rise;
endmodule

// File: rtl/bps_checker.sv
module bps_checker #(
    parameter int RES_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             mem_on,
    input logic             rd_adv,
    input logic             wr_clr,
    input logic             rd_clr,
    input logic             stat_rd,
    input logic             enc_stop,
    input logic             buf_empty,
    input logic             buf_full,
    input logic             ovf_once,
    input logic             enc_halt,
    input logic             dec_halt,
    input logic             jit_err,
    input logic             enc_run,
    input logic [RES_W-1:0] residual
);
    assert_full_ovf_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(buf_full) |-> (ovf_once && enc_halt));

    assert_full_drop_R5: assert property (@(posedge clk) disable iff (rst)
        (rd_adv || wr_clr || rd_clr) |=> !buf_full);

    assert_read_once_R6: assert property (@(posedge clk) disable iff (rst)
        (stat_rd && buf_full) |=> !ovf_once);

    assert_clr_flags_R12: assert property (@(posedge clk) disable iff (rst)
        (wr_clr || rd_clr) |=> (!ovf_once && !dec_halt && !enc_halt));

    assert_both_clr_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_clr && rd_clr) |=> (buf_empty && residual == '0));

    assert_err_off_R9: assert property (@(posedge clk) disable iff (rst)
        !mem_on |=> !jit_err);

    assert_halt_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        (enc_halt && !wr_clr && !rd_clr) |=> enc_halt);

    assert_run_kill_R11: assert property (@(posedge clk) disable iff (rst)
        (enc_stop || !mem_on) |=> !enc_run);

    assert_run_full_R11: assert property (@(posedge clk) disable iff (rst)
        buf_full |-> !enc_run);

    assert_run_err_R11: assert property (@(posedge clk) disable iff (rst)
        jit_err |-> !enc_run);

    assert_halt_needs_cause_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(dec_halt) |-> buf_empty);
endmodule

bind buf_ptr_status bps_checker #(.RES_W(RES_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .mem_on    (mem_on),
    .rd_adv    (rd_adv),
    .wr_clr    (wr_clr),
    .rd_clr    (rd_clr),
    .stat_rd   (stat_rd),
    .enc_stop  (enc_stop),
    .buf_empty (buf_empty),
    .buf_full  (buf_full),
    .ovf_once  (ovf_once),
    .enc_halt  (enc_halt),
    .dec_halt  (dec_halt),
    .jit_err   (jit_err),
    .enc_run   (enc_run),
    .residual  (residual)
);

// File: tb/buf_ptr_status_tb.sv
`timescale 1ns/1ps
module buf_ptr_status_tb;
    localparam int AW = 4;
    localparam int RW = 4;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    logic rst, mem_on, wr_adv, rd_adv, wr_clr, rd_clr, blk_clk, validate, stat_rd;
    logic frm_clk, frm_err, enc_start, enc_stop;
    logic [1:0] err_mode;
    logic buf_empty, buf_full, ovf_once, enc_halt, dec_halt, jit_err, enc_run;
    logic [RW-1:0] residual;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    buf_ptr_status #(.ADDR_W(AW), .RES_W(RW)) u_dut (
        .clk(clk), .rst(rst), .mem_on(mem_on), .wr_adv(wr_adv), .rd_adv(rd_adv),
        .wr_clr(wr_clr), .rd_clr(rd_clr), .blk_clk(blk_clk), .validate(validate),
        .stat_rd(stat_rd), .frm_clk(frm_clk), .frm_err(frm_err), .err_mode(err_mode),
        .enc_start(enc_start), .enc_stop(enc_stop), .buf_empty(buf_empty),
        .buf_full(buf_full), .ovf_once(ovf_once), .enc_halt(enc_halt),
        .dec_halt(dec_halt), .jit_err(jit_err), .enc_run(enc_run), .residual(residual)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic strobes_off();
        wr_adv = 0; rd_adv = 0; wr_clr = 0; rd_clr = 0; validate = 0;
        stat_rd = 0; enc_start = 0; enc_stop = 0;
    endtask

    task automatic writes(input int n);
        for (int i = 0; i < n; i++) begin wr_adv = 1; tick(); end
        wr_adv = 0;
    endtask

    task automatic reads(input int n);
        for (int i = 0; i < n; i++) begin rd_adv = 1; tick(); end
        rd_adv = 0;
    endtask

    task automatic clear_all();
        wr_clr = 1; rd_clr = 1; tick(); wr_clr = 0; rd_clr = 0;
    endtask

    task automatic commit();
        blk_clk = 1; tick(); blk_clk = 0; tick();
        validate = 1; tick(); validate = 0;
    endtask

    task automatic do_stat();
        stat_rd = 1; tick(); stat_rd = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: run did not finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1; mem_on = 1; blk_clk = 0; frm_clk = 0; frm_err = 0;
        err_mode = 2'b11;
        strobes_off();
        repeat (3) tick();
        rst = 0;
        tick();
        // R1 reset state
        chk("R1", "empty", buf_empty, 1);
        chk("R1", "full", buf_full, 0);
        chk("R1", "ovf", ovf_once, 0);
        chk("R1", "enc_halt", enc_halt, 0);
        chk("R1", "dec_halt", dec_halt, 0);
        chk("R1", "err", jit_err, 0);
        chk("R1", "run", enc_run, 0);
        chk("R1", "residual", residual, 0);

        // R3/R4 sweep of every read and committed position
        for (int r = 0; r < DEPTH; r++) begin
            for (int v = 0; v < DEPTH; v++) begin
                clear_all();
                reads(r);
                writes(v);
                commit();
                chk("R4", $sformatf("residual r=%0d v=%0d", r, v), residual,
                    ((v - r) & (DEPTH - 1)) & 32'hE);
                chk("R3", $sformatf("empty r=%0d v=%0d", r, v), buf_empty, (v == r) ? 1 : 0);
            end
        end

        // R2 snapshot and validate
        clear_all();
        writes(3);
        blk_clk = 1; tick();
        validate = 1; tick(); validate = 0;
        chk("R2", "rising edge captures nothing", residual, 0);
        blk_clk = 0; wr_adv = 1; tick(); wr_adv = 0;
        validate = 1; tick(); validate = 0;
        chk("R2", "capture before advance", residual, 2);
        writes(2);
        validate = 1; tick(); validate = 0;
        chk("R2", "no new edge keeps commit", residual, 2);
        blk_clk = 1; tick();
        blk_clk = 0; validate = 1; tick(); validate = 0;
        chk("R2", "same-cycle validate uses old snapshot", residual, 2);
        validate = 1; tick(); validate = 0;
        chk("R2", "next validate uses new snapshot", residual, 6);

        // R5 full trip from every read position
        for (int r = 0; r < DEPTH; r++) begin
            int n;
            n = (r == 0) ? DEPTH : r;
            clear_all();
            reads(r);
            writes(n - 1);
            chk("R5", $sformatf("not yet full r=%0d", r), buf_full, 0);
            writes(1);
            chk("R5", $sformatf("full r=%0d", r), buf_full, 1);
        end

        // R5/R6/R10/R12 full and overflow details
        clear_all();
        chk("R5", "clear equality does not set full", buf_full, 0);
        writes(DEPTH);
        chk("R6", "ovf set", ovf_once, 1);
        chk("R10", "halt from ovf", enc_halt, 1);
        do_stat();
        chk("R6", "ovf cleared by read", ovf_once, 0);
        chk("R6", "full persists", buf_full, 1);
        chk("R10", "halt survives read", enc_halt, 1);
        reads(1);
        chk("R5", "read clears full", buf_full, 0);
        wr_adv = 1; rd_adv = 1; tick(); strobes_off();
        chk("R5", "joint advance no full", buf_full, 0);
        wr_adv = 1; stat_rd = 1; tick(); strobes_off();
        chk("R6", "set beats status read", ovf_once, 1);
        chk("R5", "refilled", buf_full, 1);
        wr_clr = 1; tick(); wr_clr = 0;
        chk("R12", "wr_clr clears full", buf_full, 0);
        chk("R12", "wr_clr clears ovf", ovf_once, 0);
        chk("R12", "wr_clr clears halt", enc_halt, 0);
        chk("R12", "committed zeroed, read kept", residual, 14);

        // R7 decode halt
        clear_all();
        chk("R7", "clear leaves halt low", dec_halt, 0);
        writes(4);
        commit();
        reads(3);
        chk("R7", "not drained", dec_halt, 0);
        reads(1);
        chk("R7", "drained", dec_halt, 1);
        do_stat();
        chk("R7", "status read clears", dec_halt, 0);
        commit();
        chk("R7", "still empty, no new event", dec_halt, 0);
        writes(2);
        commit();
        reads(1);
        rd_adv = 1; stat_rd = 1; tick(); strobes_off();
        chk("R7", "drain beats status read", dec_halt, 1);

        // R8/R9/R10 error modes
        clear_all();
        frm_err = 0; frm_clk = 0; err_mode = 2'b00; tick();
        frm_clk = 1; tick();
        chk("R8", "mode 00 ignores rise", jit_err, 0);
        frm_clk = 0; tick();
        chk("R8", "mode 00 fall low sets", jit_err, 1);
        chk("R10", "halt from error", enc_halt, 1);
        do_stat();
        chk("R9", "status read clears error", jit_err, 0);
        chk("R10", "halt not cleared by read", enc_halt, 1);
        frm_err = 1; frm_clk = 1; tick(); frm_clk = 0; tick();
        chk("R8", "mode 00 fall high no set", jit_err, 0);
        frm_err = 0; mem_on = 0; frm_clk = 1; tick(); frm_clk = 0; tick();
        chk("R9", "memory off blocks set", jit_err, 0);
        mem_on = 1;
        err_mode = 2'b01; tick();
        frm_clk = 1; tick();
        chk("R8", "mode 01 rise low sets", jit_err, 1);
        frm_clk = 0; stat_rd = 1; tick(); stat_rd = 0;
        chk("R8", "mode 01 ignores fall", jit_err, 0);
        frm_err = 1; frm_clk = 1; tick(); frm_clk = 0; tick();
        chk("R8", "mode 01 rise high no set", jit_err, 0);
        err_mode = 2'b10; tick();
        chk("R8", "mode 10 high no set", jit_err, 0);
        frm_err = 0; tick();
        chk("R8", "mode 10 low sets", jit_err, 1);
        do_stat();
        chk("R9", "set beats read while low", jit_err, 1);
        mem_on = 0; tick();
        chk("R9", "memory off clears", jit_err, 0);
        frm_err = 1; mem_on = 1; tick();
        chk("R8", "mode 10 stays clear when high", jit_err, 0);
        err_mode = 2'b11; tick();
        chk("R8", "mode 11 high sets", jit_err, 1);
        frm_err = 0; do_stat();
        chk("R9", "mode 11 cleared", jit_err, 0);
        clear_all();
        chk("R10", "address clear drops halt", enc_halt, 0);

        // R11 encode running state
        enc_start = 1; tick(); strobes_off();
        chk("R11", "start", enc_run, 1);
        enc_start = 1; enc_stop = 1; tick(); strobes_off();
        chk("R11", "stop beats start", enc_run, 0);
        enc_start = 1; tick(); strobes_off();
        enc_stop = 1; tick(); strobes_off();
        chk("R11", "stop", enc_run, 0);
        mem_on = 0; enc_start = 1; tick(); strobes_off(); mem_on = 1;
        chk("R11", "memory off blocks start", enc_run, 0);
        frm_err = 1; tick();
        enc_start = 1; tick(); strobes_off();
        chk("R11", "error blocks start", enc_run, 0);
        frm_err = 0; do_stat();
        enc_start = 1; tick(); strobes_off();
        chk("R11", "restart after error cleared", enc_run, 1);
        clear_all();
        writes(DEPTH - 1);
        chk("R11", "running before full", enc_run, 1);
        writes(1);
        chk("R11", "full stops encode", enc_run, 0);
        enc_start = 1; tick(); strobes_off();
        chk("R11", "full blocks start", enc_run, 0);
        reads(1);
        enc_start = 1; tick(); strobes_off();
        chk("R11", "start after full drops", enc_run, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule